// File: doc/BRIEF.md
# Pseudo-SRAM Mode Register Unlock Detector

This block sits beside the bus interface of a pseudo-SRAM and watches ordinary completed bus cycles for a hidden four-cycle pattern. Once it sees that pattern, it loads a small mode register. The register holds a two-bit retained-density code for partial-refresh standby and a page-length flag. No storage area of the array is reserved for commands: the pattern is made only of normal reads and writes to the topmost word address.

The interface controller reports each finished bus cycle with a one-clock event. With the event it gives the direction, the word address, the written data, and two strobes. The strobes tell whether chip-select and output-enable were toggled (deasserted and reasserted) for that cycle. The detector checks the following:
- the cycle order: read, read, write of zero, write of a command;
- the toggle discipline on every cycle;
- the number of back-to-back reads of the top address.

A successful pattern updates the register and raises a one-clock loaded pulse. A pattern that breaks off after at least one matching cycle raises a one-clock aborted pulse. A separate valid bit tells a standby controller whether the register has ever been loaded since reset.

Top module: `mreg_unlock_detect`

## Requirements
- R1: After reset, cfg_valid, cfg_page8, cfg_density, load_pulse and abort_pulse are all 0.
- R2: The following four consecutive events, all at address 0x1FFFFF, load the register:
  - a read with both toggle strobes high;
  - a read with both toggle strobes high;
  - a write of 0x0000 with cs_toggled high;
  - a write of a command with cs_toggled high.
  The command is valid when bits 15:3 are zero and bit 2 is one. The register then takes cfg_density = data bits 1:0, cfg_page8 = 1 and cfg_valid = 1, and load_pulse is high for exactly one clock after the fourth event's clock edge.
- R3: The command values 0x04, 0x05, 0x06 and 0x07 give cfg_density 0, 1, 2 and 3 respectively (retention of half, quarter, eighth and none of the array).
- R4: A wrong address, wrong data in the third write, or cycles in the wrong order cause no load, and the register keeps its value.
- R5: If cs_toggled is low on any of the four events, or oe_toggled is low on either read, no load occurs.
- R6: A read of 0x1FFFFF arriving after two matching reads cancels the entry and raises abort_pulse. The following zero write and command write then do not load.
- R7: After a cancel, further reads of 0x1FFFFF do not start a new sequence and raise no pulse. Any other event releases the block, after which a full sequence loads normally.
- R8: abort_pulse lasts one clock and fires only when a sequence leaves early after at least one matching event. A non-matching event while idle raises no pulse. load_pulse and abort_pulse are never high together.
- R9: Clocks without an event are ignored, including clocks in the middle of a sequence. The register holds its value until the next successful load.
- R10: A final write whose bits 15:3 are nonzero, or whose bit 2 is zero, is rejected with abort_pulse and leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | One-clock strobe: a bus cycle completed |
| cyc_write | input | 1 | 1 = the completed cycle was a write, 0 = a read |
| cyc_addr | input | 21 | Word address of the completed cycle |
| cyc_wdata | input | 16 | Data written (ignored for reads) |
| cs_toggled | input | 1 | Chip-select was toggled for this cycle |
| oe_toggled | input | 1 | Output-enable was toggled for this cycle |
| cfg_density | output | 2 | Retained-density code |
| cfg_page8 | output | 1 | Page-length flag, 1 = eight words |
| cfg_valid | output | 1 | Register has been loaded since reset |
| load_pulse | output | 1 | One-clock pulse on a successful load |
| abort_pulse | output | 1 | One-clock pulse on an early exit |

## Verification
The delicate overlap is a single read of the top address that both cancels an entry in progress and looks like the first step of a new entry. The bench provokes it by issuing three, four and five back-to-back reads of 0x1FFFFF, each followed by the zero write and a command. It judges the result by seeing one abort on the third read, no pulse on later reads, and no load. It then shows that a single unrelated cycle clears the lockout and lets a full pattern load.

// File: rtl/mreg_unlock_pkg.sv
package mreg_unlock_pkg;

  localparam int DENS_W   = 2;
  localparam int PAGE_BIT = DENS_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_WR0,
    ST_HOLD
  } seq_state_e;

  typedef struct packed {
    logic              valid;
    logic              page8;
    logic [DENS_W-1:0] density;
  } mode_cfg_t;

  typedef struct packed {
    logic key_rd;
    logic rd_ok;
    logic zero_wr_ok;
    logic cmd_wr_ok;
  } cyc_class_t;

endpackage

// File: rtl/mreg_cyc_classify.sv
module mreg_cyc_classify
  import mreg_unlock_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_wdata,
  input  logic              cs_toggled,
  input  logic              oe_toggled,
  output cyc_class_t        cls
);

  localparam logic [ADDR_W-1:0] KEY_ADDR = {ADDR_W{1'b1}};
  localparam int                UPPER_LO = PAGE_BIT + 1;

  logic key_hit;
  logic upper_zero;

  always_comb begin
    key_hit    = (cyc_addr == KEY_ADDR);
    upper_zero = (cyc_wdata[DATA_W-1:UPPER_LO] == '0);

    cls.key_rd     = key_hit && !cyc_write;
    cls.rd_ok      = key_hit && !cyc_write && cs_toggled && oe_toggled;
    cls.zero_wr_ok = key_hit && cyc_write && cs_toggled && (cyc_wdata == '0);
    cls.cmd_wr_ok  = key_hit && cyc_write && cs_toggled && upper_zero
                     && cyc_wdata[PAGE_BIT];
  end

endmodule

// File: rtl/mreg_seq_fsm.sv
module mreg_seq_fsm
  import mreg_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_valid,
  input  cyc_class_t cls,
  output logic       load_en,
  output logic       load_pulse,
  output logic       abort_pulse
);

  seq_state_e state_q, state_d;
  logic       abort_d;
  logic       load_q, abort_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    abort_d = 1'b0;
    if (cyc_valid) begin
      unique case (state_q)
        ST_IDLE: begin
          if (cls.rd_ok) state_d = ST_RD1;
        end
        ST_RD1: begin
          if (cls.rd_ok) begin
            state_d = ST_RD2;
          end else begin
            state_d = ST_IDLE;
            abort_d = 1'b1;
          end
        end
        ST_RD2: begin
          if (cls.key_rd) begin
            state_d = ST_HOLD;      // third back-to-back top read
            abort_d = 1'b1;
          end else if (cls.zero_wr_ok) begin
            state_d = ST_WR0;
          end else begin
            state_d = ST_IDLE;
            abort_d = 1'b1;
          end
        end
        ST_WR0: begin
          state_d = ST_IDLE;
          if (cls.cmd_wr_ok) load_en = 1'b1;
          else               abort_d = 1'b1;
        end
        ST_HOLD: begin
          if (!cls.key_rd) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      load_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      load_q  <= load_en;
      abort_q <= abort_d;
    end
  end

  assign load_pulse  = load_q;
  assign abort_pulse = abort_q;

  a_r2_load_follows_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> ($past(state_q) == ST_WR0));

  a_r6_third_read_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD2 && cyc_valid && cls.key_rd) |=> (abort_q && state_q == ST_HOLD));

  a_r7_hold_ignores_top_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && cyc_valid && cls.key_rd)
      |=> (state_q == ST_HOLD && !abort_q && !load_q));

  a_r8_idle_never_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> !abort_q);

  a_r9_no_event_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> ($stable(state_q) && !load_q && !abort_q));

endmodule

// File: rtl/mreg_cfg_reg.sv
module mreg_cfg_reg
  import mreg_unlock_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [PAGE_BIT:0]   cmd_bits,
  output mode_cfg_t           cfg
);

  mode_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load_en) begin
      cfg_d.valid   = 1'b1;
      cfg_d.page8   = cmd_bits[PAGE_BIT];
      cfg_d.density = cmd_bits[DENS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  a_r9_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(cfg_q));

  a_r2_load_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cfg_q.valid && cfg_q.page8));

endmodule

// File: rtl/mreg_unlock_detect.sv
module mreg_unlock_detect
  import mreg_unlock_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_wdata,
  input  logic              cs_toggled,
  input  logic              oe_toggled,
  output logic [1:0]        cfg_density,
  output logic              cfg_page8,
  output logic              cfg_valid,
  output logic              load_pulse,
  output logic              abort_pulse
);

  cyc_class_t cls;
  mode_cfg_t  cfg;
  logic       load_en;

  mreg_cyc_classify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_classify (
    .cyc_write  (cyc_write),
    .cyc_addr   (cyc_addr),
    .cyc_wdata  (cyc_wdata),
    .cs_toggled (cs_toggled),
    .oe_toggled (oe_toggled),
    .cls        (cls)
  );

  mreg_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_valid   (cyc_valid),
    .cls         (cls),
    .load_en     (load_en),
    .load_pulse  (load_pulse),
    .abort_pulse (abort_pulse)
  );

  mreg_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .cmd_bits (cyc_wdata[PAGE_BIT:0]),
    .cfg      (cfg)
  );

  assign cfg_density = cfg.density;
  assign cfg_page8   = cfg.page8;
  assign cfg_valid   = cfg.valid;

  a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_pulse && abort_pulse));

  a_r1_invalid_means_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (!cfg_page8 && cfg_density == 2'd0));

endmodule

// File: tb/mreg_unlock_detect_bench.sv
module mreg_unlock_detect_bench;

  localparam logic [20:0] KEY = 21'h1FFFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_valid, cyc_write, cs_t, oe_t;
  logic [20:0] addr;
  logic [15:0] wdata;
  logic [1:0]  cfg_density;
  logic        cfg_page8, cfg_valid, load_pulse, abort_pulse;

  int  n_chk = 0;
  int  n_err = 0;
  bit  seen_load, seen_abort, last_load, last_abort;
  bit  exp_valid, exp_page;
  bit [1:0] exp_dens;

  always #5 clk = ~clk;

  mreg_unlock_detect u_mreg_unlock_detect (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
    .cyc_addr(addr), .cyc_wdata(wdata), .cs_toggled(cs_t), .oe_toggled(oe_t),
    .cfg_density(cfg_density), .cfg_page8(cfg_page8), .cfg_valid(cfg_valid),
    .load_pulse(load_pulse), .abort_pulse(abort_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [20:0] a, input logic [15:0] d,
                     input bit cs, input bit oe);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_write = wr; addr = a; wdata = d; cs_t = cs; oe_t = oe;
    @(posedge clk);
    #2;
    last_load  = load_pulse;
    last_abort = abort_pulse;
    if (load_pulse)  seen_load  = 1'b1;
    if (abort_pulse) seen_abort = 1'b1;
    cyc_valid = 1'b0;
  endtask

  task automatic clear_seen();
    seen_load = 1'b0; seen_abort = 1'b0;
  endtask

  task automatic check_cfg(input string tag);
    chk({cfg_valid, cfg_page8, cfg_density} == {exp_valid, exp_page, exp_dens}, tag,
        int'({cfg_valid, cfg_page8, cfg_density}), int'({exp_valid, exp_page, exp_dens}));
  endtask

  task automatic full_seq(input logic [15:0] cmd, input bit [3:0] cs, input bit [1:0] oe);
    clear_seen();
    bus(1'b0, KEY, 16'h0, cs[0], oe[0]);
    bus(1'b0, KEY, 16'h0, cs[1], oe[1]);
    bus(1'b1, KEY, 16'h0000, cs[2], 1'b0);
    bus(1'b1, KEY, cmd, cs[3], 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_valid = 1'b0; cyc_write = 1'b0; addr = '0; wdata = '0;
    cs_t = 1'b0; oe_t = 1'b0;
    exp_valid = 1'b0; exp_page = 1'b0; exp_dens = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    check_cfg("R1 reset cfg");
    chk(!load_pulse && !abort_pulse, "R1 reset pulses", int'({load_pulse, abort_pulse}), 0);

    // R5 / R8 exhaustive toggle sweep
    for (int m = 0; m < 64; m++) begin
      bit [3:0] csm;
      bit [1:0] oem;
      bit ok, m1, m2;
      csm = m[3:0]; oem = m[5:4];
      ok = (csm == 4'hF) && (oem == 2'b11);
      m1 = csm[0] && oem[0];
      m2 = csm[1] && oem[1];
      full_seq(16'h0005, csm, oem);
      chk(last_load == ok && seen_load == ok, "R5 toggle load", int'(seen_load), int'(ok));
      chk(seen_abort == (!ok && (m1 || m2)), "R8 toggle abort", int'(seen_abort),
          int'(!ok && (m1 || m2)));
      if (ok) begin exp_valid = 1; exp_page = 1; exp_dens = 2'd1; end
      check_cfg("R9 cfg after toggle sweep");
    end

    // R3 / R10 command value sweep
    for (int c = 0; c < 19; c++) begin
      logic [15:0] cmd;
      bit ok;
      cmd = (c < 16) ? 16'(c) : (c == 16) ? 16'h0104 : (c == 17) ? 16'h0804 : 16'h8007;
      ok = (cmd >= 16'd4) && (cmd <= 16'd7);
      full_seq(cmd, 4'hF, 2'b11);
      chk(last_load == ok, "R3 command accept", int'(last_load), int'(ok));
      chk(last_abort == !ok, "R10 command reject abort", int'(last_abort), int'(!ok));
      if (ok) begin exp_valid = 1; exp_page = 1; exp_dens = cmd[1:0]; end
      check_cfg("R3 density after command");
      // R2 pulse length: one idle clock later both pulses low
      @(posedge clk); #2;
      chk(!load_pulse && !abort_pulse, "R2 pulse one clock", int'({load_pulse, abort_pulse}), 0);
    end

    // R4 wrong address on third cycle
    clear_seen();
    bus(1'b0, KEY, 0, 1, 1); bus(1'b0, KEY, 0, 1, 1);
    bus(1'b1, KEY - 21'd1, 0, 1, 0); bus(1'b1, KEY, 16'h0004, 1, 0);
    chk(!seen_load && seen_abort, "R4 wrong address", int'(seen_load), 0);
    check_cfg("R4 cfg kept after wrong address");

    // R4 wrong zero-write data
    clear_seen();
    full_seq(16'h0006, 4'hF, 2'b11);
    exp_dens = 2'd2;
    clear_seen();
    bus(1'b0, KEY, 0, 1, 1); bus(1'b0, KEY, 0, 1, 1);
    bus(1'b1, KEY, 16'h0001, 1, 0); bus(1'b1, KEY, 16'h0004, 1, 0);
    chk(!seen_load, "R4 wrong zero data", int'(seen_load), 0);
    check_cfg("R4 cfg kept after wrong data");

    // R4 wrong order
    clear_seen();
    bus(1'b1, KEY, 16'h0000, 1, 0); bus(1'b0, KEY, 0, 1, 1);
    bus(1'b0, KEY, 0, 1, 1); bus(1'b1, KEY, 16'h0004, 1, 0);
    chk(!seen_load, "R4 wrong order", int'(seen_load), 0);
    check_cfg("R4 cfg kept after wrong order");

    // R8 idle mismatch raises nothing
    clear_seen();
    bus(1'b1, 21'h000123, 16'h0004, 1, 1); bus(1'b0, 21'h000010, 0, 1, 1);
    chk(!seen_abort && !seen_load, "R8 idle mismatch no pulse", int'(seen_abort), 0);

    // R6 / R7 cancel by extra reads: 3, 4 and 5 reads
    for (int nr = 3; nr <= 5; nr++) begin
      clear_seen();
      bus(1'b0, KEY, 0, 1, 1); bus(1'b0, KEY, 0, 1, 1);
      bus(1'b0, KEY, 0, 1, 1);
      chk(last_abort == 1'b1, "R6 third read abort", int'(last_abort), 1);
      for (int k = 3; k < nr; k++) begin
        bus(1'b0, KEY, 0, 1, 1);
        chk(!last_abort && !last_load, "R7 held read no pulse", int'({last_load, last_abort}), 0);
      end
      bus(1'b1, KEY, 16'h0000, 1, 0); bus(1'b1, KEY, 16'h0007, 1, 0);
      chk(!seen_load, "R6 no load after cancel", int'(seen_load), 0);
      check_cfg("R6 cfg kept after cancel");
    end

    // R7 release by unrelated cycle, then full pattern loads
    clear_seen();
    bus(1'b0, KEY, 0, 1, 1); bus(1'b0, KEY, 0, 1, 1); bus(1'b0, KEY, 0, 1, 1);
    bus(1'b0, 21'h000000, 0, 1, 1);
    full_seq(16'h0007, 4'hF, 2'b11);
    exp_dens = 2'd3;
    chk(last_load, "R7 load after release", int'(last_load), 1);
    check_cfg("R7 cfg after release");

    // R9 idle clocks inside a sequence
    clear_seen();
    bus(1'b0, KEY, 0, 1, 1); repeat (4) @(posedge clk);
    bus(1'b0, KEY, 0, 1, 1); repeat (2) @(posedge clk);
    bus(1'b1, KEY, 0, 1, 0); repeat (5) @(posedge clk);
    bus(1'b1, KEY, 16'h0004, 1, 0);
    exp_dens = 2'd0;
    chk(last_load && !seen_abort, "R9 gaps ignored", int'(last_load), 1);
    check_cfg("R9 cfg after gapped sequence");
    repeat (10) @(posedge clk);
    #2;
    check_cfg("R9 cfg held over idle clocks");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule